// File: doc/BRIEF.md
# Slow-Clock Real-Time Counter with Seconds Alarm

This block keeps time on a slow always-on clock and is controlled from a fast bus clock through 32-bit registers. A 47-bit counter advances by one on every slow-clock edge while counting is switched on. The low 15 bits of the counter are a binary fraction of a second, and the 32 bits above them are whole seconds. A seconds alarm compares the whole-seconds field with a programmed value. When the alarm is armed and the two are equal, a sticky alarm flag is raised. That flag drives an interrupt line, and also a wakeup line when wakeup is armed.

All configuration written on the bus (the three enable bits, the alarm value and counter loads) is gathered into one bundle and carried into the slow domain by a toggle request/acknowledge handshake. In the other direction, the slow domain streams snapshots of the counter, the applied enables and the alarm-match level back to the bus domain through a second handshake. As a result, the enable bits read back from the control register show the state that is actually in force in the slow domain. Software must poll them after changing them.

Software sets the time in three steps: switch counting off, wait until the readback shows it off, then write the low and high counter words. A counter read is a pair of accesses that can straddle a snapshot update, so software reads the pair twice and repeats until both reads agree.

Top module: `slow_rtc_top`

## Requirements
- R1: After reset every mapped register reads zero and both `irq` and `wake` are low.
- R2: Byte offsets are: control 0x04, status 0x18, counter-high 0x1C, counter-low 0x20, alarm 0x24, glitch-detect 0x30. Any other offset reads zero.
- R3: Control bit 0 enables counting, bit 1 arms the alarm and bit 3 arms wakeup. Reading control returns the values applied in the slow domain. The first read after a write still shows the old value, and the new value appears within 1000 polls.
- R4: While enabled, the counter rises by one per slow-clock edge. Counter-low returns bits 31:0. Counter-high returns bits 46:32 in its bits 14:0, with zeros above.
- R5: Counter words written while counting is off are loaded into the counter exactly. A counter write made while counting is on has no effect on the count.
- R6: The alarm and glitch-detect registers read back the last 32-bit value written, including 0x41736166 for glitch-detect.
- R7: Status bit 0 sets when counter bits 46:15 become equal to the alarm register while the alarm is armed.
- R8: With the alarm not armed, passing the alarm second leaves status bit 0 clear.
- R9: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. The flag does not set again while the same match persists, and a new match in the same cycle as a clear wins.
- R10: `irq` is status bit 0 ANDed with the written alarm-arm bit, and it follows that bit within one bus cycle. `wake` is `irq` ANDed with the written wakeup-arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-interface clock |
| slow_clk | input | 1 | Slow timekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several slow cycles |
| bus_sel | input | 1 | Register access strobe, one bus cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
The checker checks the following on every cycle: the counter steps by exactly one on each slow edge while enabled, it stays put while disabled and no transfer lands, `irq` never rises without the flag, `wake` never rises without `irq`, and the write-one-to-clear and hold behaviour of the flag. Only the bench scenarios can show the things that depend on a whole sequence. These are the lag of the control readback, exact loads, writes ignored while counting, the alarm firing at the right second and not firing when it is not armed, and the flag staying clear under a persisting match. The bench's reference model also checks `irq` and `wake` against the written arm bits on every bus clock.

// File: rtl/rtc_lp_pkg.sv
// Shared constants for the slow-clock real-time counter.
// Assumes byte addressing with a 4-byte register stride.
package rtc_lp_pkg;
    localparam int REG_W = 32;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h18;
    localparam logic [7:0] OFS_CNT_HI = 8'h1C;
    localparam logic [7:0] OFS_CNT_LO = 8'h20;
    localparam logic [7:0] OFS_ALARM  = 8'h24;
    localparam logic [7:0] OFS_GLITCH = 8'h30;
    localparam int BIT_RUN  = 0;
    localparam int BIT_ARM  = 1;
    localparam int BIT_WAKE = 3;
    localparam int BIT_FLAG = 0;
endpackage

// File: rtl/rtc_bit_sync.sv
// Multi-flop synchroniser for a single level signal.
// Assumes the input is a flop output in another domain that changes slowly
// compared with the destination clock.
module rtc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_hs_xfer.sv
// Toggle request/acknowledge transfer of a W-bit word between two clocks.
// The source holds the word steady until the acknowledge toggle returns, so the
// destination samples stable data. Assumes both sides share one reset that is
// held across several cycles of the slower clock.
module rtc_hs_xfer #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         src_launch,
    input  logic [W-1:0] src_data,
    output logic         src_idle,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic         dst_valid,
    output logic [W-1:0] dst_data
);
    logic         req_tgl;
    logic         ack_at_src;
    logic         req_at_dst;
    logic         req_seen;
    logic [W-1:0] hold_q;

    assign src_idle = (req_tgl == ack_at_src);

    // Source: latch the word and flip the request when idle.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            req_tgl <= 1'b0;
            hold_q  <= '0;
        end else if (src_idle && src_launch) begin
            req_tgl <= ~req_tgl;
            hold_q  <= src_data;
        end
    end

    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_at_dst)
    );

    // Destination: detect a request toggle and capture the held word.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            req_seen  <= 1'b0;
            dst_valid <= 1'b0;
            dst_data  <= '0;
        end else begin
            req_seen  <= req_at_dst;
            dst_valid <= (req_at_dst != req_seen);
            if (req_at_dst != req_seen) dst_data <= hold_q;
        end
    end

    rtc_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(req_seen), .q(ack_at_src)
    );
endmodule

// File: rtl/rtc_slow_core.sv
// Slow-domain timekeeper: applies configuration bundles, runs the counter and
// evaluates the seconds match. Assumes the bundle layout
// {load, load_value, alarm, wake_en, arm_en, run_en} from the bus side.
module rtc_slow_core #(
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_valid,
    input  logic [CNT_W+CNT_W-FRAC_W+3:0]   cfg_data,
    output logic [CNT_W+3:0]                snap_data,
    output logic [CNT_W-1:0]                cnt_o,
    output logic                            run_o
);
    localparam int SEC_W = CNT_W - FRAC_W;

    logic             run_q, arm_q, wake_q;
    logic [SEC_W-1:0] alarm_q;
    logic [CNT_W-1:0] cnt_q;
    logic             match;

    logic             c_run, c_arm, c_wake, c_load;
    logic [SEC_W-1:0] c_alarm;
    logic [CNT_W-1:0] c_val;

    assign {c_load, c_val, c_alarm, c_wake, c_arm, c_run} = cfg_data;

    // Apply enables and the alarm value when a bundle arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            arm_q   <= 1'b0;
            wake_q  <= 1'b0;
            alarm_q <= '0;
        end else if (cfg_valid) begin
            run_q   <= c_run;
            arm_q   <= c_arm;
            wake_q  <= c_wake;
            alarm_q <= c_alarm;
        end
    end

    // Count while running; accept a load only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (cfg_valid && c_load && !run_q) cnt_q <= c_val;
        else if (run_q)                       cnt_q <= cnt_q + 1'b1;
    end

    assign match     = arm_q && (cnt_q[CNT_W-1:FRAC_W] == alarm_q);
    assign snap_data = {match, wake_q, arm_q, run_q, cnt_q};
    assign cnt_o     = cnt_q;
    assign run_o     = run_q;
endmodule

// File: rtl/rtc_bus_regs.sv
// Bus-domain register bank: write shadows, counter holding words, snapshot
// capture, the sticky alarm flag and the interrupt outputs. Assumes a one-cycle
// strobe per access and a read result registered one cycle later.
module rtc_bus_regs
    import rtc_lp_pkg::*;
#(
    parameter int CNT_W  = 47,
    parameter int FRAC_W = 15,
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [REG_W-1:0]              bus_wdata,
    output logic [REG_W-1:0]              bus_rdata,
    output logic                          cfg_launch,
    input  logic                          cfg_idle,
    output logic [CNT_W+CNT_W-FRAC_W+3:0] cfg_data,
    input  logic                          snap_valid,
    input  logic [CNT_W+3:0]              snap_data,
    output logic                          flag_o,
    output logic                          flag_set_o,
    output logic                          irq,
    output logic                          wake
);
    localparam int SEC_W = CNT_W - FRAC_W;
    localparam int HI_W  = CNT_W - REG_W;

    logic             run_sh, arm_sh, wake_sh;
    logic [SEC_W-1:0] alarm_sh;
    logic [REG_W-1:0] glitch_q;
    logic [CNT_W-1:0] hold_cnt;
    logic             dirty_q, load_q;
    logic [CNT_W-1:0] snap_cnt;
    logic             snap_run, snap_arm, snap_wake, snap_match;
    logic             match_prev, flag_q, flag_set;
    logic [REG_W-1:0] rd_mux;

    logic wr_hit, rd_hit;
    logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_glitch;

    assign wr_hit    = bus_sel && bus_wr;
    assign rd_hit    = bus_sel && !bus_wr;
    assign wr_ctrl   = wr_hit && (bus_addr == OFS_CTRL[ADDR_W-1:0]);
    assign wr_stat   = wr_hit && (bus_addr == OFS_STAT[ADDR_W-1:0]);
    assign wr_hi     = wr_hit && (bus_addr == OFS_CNT_HI[ADDR_W-1:0]);
    assign wr_lo     = wr_hit && (bus_addr == OFS_CNT_LO[ADDR_W-1:0]);
    assign wr_alarm  = wr_hit && (bus_addr == OFS_ALARM[ADDR_W-1:0]);
    assign wr_glitch = wr_hit && (bus_addr == OFS_GLITCH[ADDR_W-1:0]);

    // Hold the written control, alarm and glitch-detect values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_sh   <= 1'b0;
            arm_sh   <= 1'b0;
            wake_sh  <= 1'b0;
            alarm_sh <= '0;
            glitch_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_sh  <= bus_wdata[BIT_RUN];
                arm_sh  <= bus_wdata[BIT_ARM];
                wake_sh <= bus_wdata[BIT_WAKE];
            end
            if (wr_alarm)  alarm_sh <= bus_wdata[SEC_W-1:0];
            if (wr_glitch) glitch_q <= bus_wdata;
        end
    end

    // Collect counter words and mark the configuration for transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            dirty_q  <= 1'b0;
            load_q   <= 1'b0;
        end else begin
            if (cfg_launch && cfg_idle) begin
                dirty_q <= 1'b0;
                load_q  <= 1'b0;
            end
            if (wr_ctrl || wr_alarm || wr_lo || wr_hi) dirty_q <= 1'b1;
            if (wr_lo || wr_hi) load_q <= 1'b1;
            if (wr_lo) hold_cnt[REG_W-1:0] <= bus_wdata;
            if (wr_hi) hold_cnt[CNT_W-1:REG_W] <= bus_wdata[HI_W-1:0];
        end
    end

    assign cfg_launch = dirty_q;
    assign cfg_data   = {load_q, hold_cnt, alarm_sh, wake_sh, arm_sh, run_sh};

    // Capture the latest snapshot delivered from the slow domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_cnt   <= '0;
            snap_run   <= 1'b0;
            snap_arm   <= 1'b0;
            snap_wake  <= 1'b0;
            snap_match <= 1'b0;
            match_prev <= 1'b0;
        end else if (snap_valid) begin
            {snap_match, snap_wake, snap_arm, snap_run, snap_cnt} <= snap_data;
            match_prev <= snap_match;
        end
    end

    // A new match raises the flag; that beats a same-cycle clear.
    assign flag_set = snap_valid && snap_data[CNT_W+3] && !snap_match;

    // Sticky alarm flag with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   flag_q <= 1'b0;
        else if (flag_set)                            flag_q <= 1'b1;
        else if (wr_stat && bus_wdata[BIT_FLAG])      flag_q <= 1'b0;
    end

    // Select the register addressed by a read.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CTRL[ADDR_W-1:0]: begin
                rd_mux[BIT_RUN]  = snap_run;
                rd_mux[BIT_ARM]  = snap_arm;
                rd_mux[BIT_WAKE] = snap_wake;
            end
            OFS_STAT[ADDR_W-1:0]:   rd_mux[BIT_FLAG] = flag_q;
            OFS_CNT_HI[ADDR_W-1:0]: rd_mux[HI_W-1:0] = snap_cnt[CNT_W-1:REG_W];
            OFS_CNT_LO[ADDR_W-1:0]: rd_mux = snap_cnt[REG_W-1:0];
            OFS_ALARM[ADDR_W-1:0]:  rd_mux[SEC_W-1:0] = alarm_sh;
            OFS_GLITCH[ADDR_W-1:0]: rd_mux = glitch_q;
            default:                rd_mux = '0;
        endcase
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_hit) bus_rdata <= rd_mux;
    end

    assign irq        = flag_q && arm_sh;
    assign wake       = irq && wake_sh;
    assign flag_o     = flag_q;
    assign flag_set_o = flag_set;
    logic unused_match_prev;
    assign unused_match_prev = match_prev;
endmodule

// File: rtl/slow_rtc_top.sv
// Top level of the slow-clock real-time counter with seconds alarm.
// Assumes rst_n is synchronous to both clocks in effect, that is, it is held low
// for several slow-clock cycles.
module slow_rtc_top #(
    parameter int CNT_W       = 47,
    parameter int FRAC_W      = 15,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wake
);
    localparam int SEC_W  = CNT_W - FRAC_W;
    localparam int CFG_W  = CNT_W + SEC_W + 4;
    localparam int SNAP_W = CNT_W + 4;

    logic              cfg_launch, cfg_idle, cfg_valid_slow;
    logic [CFG_W-1:0]  cfg_bus, cfg_slow;
    logic              snap_idle_unused, snap_valid_bus;
    logic [SNAP_W-1:0] snap_slow, snap_bus;
    logic [CNT_W-1:0]  slow_cnt;
    logic              slow_run;
    logic              alarm_flag, alarm_set;

    rtc_bus_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(bus_clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_launch(cfg_launch), .cfg_idle(cfg_idle), .cfg_data(cfg_bus),
        .snap_valid(snap_valid_bus), .snap_data(snap_bus),
        .flag_o(alarm_flag), .flag_set_o(alarm_set),
        .irq(irq), .wake(wake)
    );

    rtc_hs_xfer #(.W(CFG_W), .SYNC_STAGES(SYNC_STAGES)) u_cfg_xfer (
        .src_clk(bus_clk), .src_rst_n(rst_n), .src_launch(cfg_launch),
        .src_data(cfg_bus), .src_idle(cfg_idle),
        .dst_clk(slow_clk), .dst_rst_n(rst_n),
        .dst_valid(cfg_valid_slow), .dst_data(cfg_slow)
    );

    rtc_slow_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_core (
        .clk(slow_clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid_slow), .cfg_data(cfg_slow),
        .snap_data(snap_slow), .cnt_o(slow_cnt), .run_o(slow_run)
    );

    rtc_hs_xfer #(.W(SNAP_W), .SYNC_STAGES(SYNC_STAGES)) u_snap_xfer (
        .src_clk(slow_clk), .src_rst_n(rst_n), .src_launch(1'b1),
        .src_data(snap_slow), .src_idle(snap_idle_unused),
        .dst_clk(bus_clk), .dst_rst_n(rst_n),
        .dst_valid(snap_valid_bus), .dst_data(snap_bus)
    );
endmodule

// File: rtl/rtc_lp_checker.sv
// Property checker for slow_rtc_top, attached through bind.
module rtc_lp_checker #(
    parameter int CNT_W  = 47,
    parameter int ADDR_W = 6
) (
    input logic              bus_clk,
    input logic              slow_clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic              wake,
    input logic              alarm_flag,
    input logic              alarm_set,
    input logic              slow_run,
    input logic              cfg_valid_slow,
    input logic [CNT_W-1:0]  slow_cnt
);
    logic stat_clear;
    assign stat_clear = bus_sel && bus_wr && (bus_addr == 6'h18) && bus_wdata[0];

    assert_wake_needs_irq_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        wake |-> irq);
    assert_irq_needs_flag_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        irq |-> alarm_flag);
    assert_w1c_clears_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (stat_clear && !alarm_set) |=> !alarm_flag);
    assert_flag_sticky_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!stat_clear && !alarm_set) |=> $stable(alarm_flag));
    assert_count_step_R4: assert property (@(posedge slow_clk) disable iff (!rst_n)
        slow_run |=> (slow_cnt == CNT_W'($past(slow_cnt) + 1'b1)));
    assert_hold_stopped_R5: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!slow_run && !cfg_valid_slow) |=> $stable(slow_cnt));
endmodule

bind slow_rtc_top rtc_lp_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_checker (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq(irq), .wake(wake), .alarm_flag(alarm_flag), .alarm_set(alarm_set),
    .slow_run(slow_run), .cfg_valid_slow(cfg_valid_slow), .slow_cnt(slow_cnt)
);

// File: tb/test_slow_rtc_top.sv
// Self-checking bench: scenario checks plus a per-clock reference model of the
// interrupt outputs derived from the written arm bits.
module test_slow_rtc_top;
    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit m_arm = 1'b0;
    bit m_wake = 1'b0;

    slow_rtc_top i_slow_rtc_top (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    always #10 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #80 slow_clk = ~slow_clk;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model: irq/wake versus written arm bits, every clock.
    always @(posedge bus_clk) begin
        cycles++;
        #5;
        if (model_on) begin
            check(wake === (irq & m_wake), "R10 wake model", wake, irq & m_wake);
            if (!m_arm) check(irq === 1'b0, "R10 irq gated", irq, 0);
        end
    end

    always @(posedge bus_clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 6'h04) begin
            m_arm = d[1];
            m_wake = d[3];
        end
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge bus_clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_count(output logic [46:0] v);
        logic [31:0] h1, l1, h2, l2;
        v = '0;
        for (int k = 0; k < 50; k++) begin
            bus_read(6'h1C, h1); bus_read(6'h20, l1);
            bus_read(6'h1C, h2); bus_read(6'h20, l2);
            if (h1 == h2 && l1 == l2) begin
                v = {h1[14:0], l1};
                break;
            end
        end
    endtask

    task automatic poll_ctrl(input logic [31:0] want, output int polls);
        logic [31:0] d;
        polls = 0;
        for (int k = 0; k < 1000; k++) begin
            bus_read(6'h04, d);
            polls++;
            if (d == want) break;
        end
    endtask

    task automatic load_time(input logic [31:0] sec, input logic [14:0] frac);
        int p;
        logic [46:0] v;
        bus_write(6'h04, 32'h0);
        poll_ctrl(32'h0, p);
        bus_write(6'h20, {sec[16:0], frac});
        bus_write(6'h1C, {17'h0, sec[31:17]});
        repeat (120) @(negedge bus_clk);
        read_count(v);
        check(v == {sec, frac}, "R5 load while stopped", v, {sec, frac});
    endtask

    task automatic wait_irq(input int limit, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < limit; k++) begin
            @(negedge bus_clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [46:0] v1, v2;
        int p;
        bit seen;

        repeat (60) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (40) @(negedge bus_clk);
        model_on = 1'b1;

        // R1: reset values.
        check(irq == 1'b0 && wake == 1'b0, "R1 outputs low", {irq, wake}, 0);
        bus_read(6'h04, d); check(d == 0, "R1 control", d, 0);
        bus_read(6'h18, d); check(d == 0, "R1 status", d, 0);
        bus_read(6'h1C, d); check(d == 0, "R1 counter high", d, 0);
        bus_read(6'h20, d); check(d == 0, "R1 counter low", d, 0);
        bus_read(6'h24, d); check(d == 0, "R1 alarm", d, 0);
        bus_read(6'h30, d); check(d == 0, "R1 glitch", d, 0);

        // R6 register readback; R2 unmapped offset.
        bus_write(6'h30, 32'h41736166);
        bus_read(6'h30, d); check(d == 32'h41736166, "R6 glitch readback", d, 32'h41736166);
        bus_write(6'h24, 32'hCAFE1234);
        bus_read(6'h24, d); check(d == 32'hCAFE1234, "R6 alarm readback", d, 32'hCAFE1234);
        bus_read(6'h08, d); check(d == 0, "R2 unmapped reads zero", d, 0);
        bus_read(6'h2C, d); check(d == 0, "R2 unmapped reads zero", d, 0);

        // R3: enable readback lags, then appears.
        bus_write(6'h04, 32'h1);
        bus_read(6'h04, d); check(d == 0, "R3 first readback old", d, 0);
        poll_ctrl(32'h1, p);
        check(p > 0 && p < 1000, "R3 enable applied in polls", p, 1);

        // R4: counter advances while enabled.
        read_count(v1);
        repeat (400) @(negedge bus_clk);
        read_count(v2);
        check(v2 > v1 && v2 - v1 <= 80, "R4 counter advances", v2 - v1, 50);

        // R5: load while stopped, then ignore writes while running.
        load_time(32'h0012345, 15'h7F00);
        bus_write(6'h04, 32'h1);
        poll_ctrl(32'h1, p);
        bus_write(6'h20, 32'h0);
        bus_write(6'h1C, 32'h0);
        repeat (120) @(negedge bus_clk);
        read_count(v1);
        check(v1 > {32'h12345, 15'h7F00}, "R5 write ignored while running", v1, {32'h12345, 15'h7F00});
        check(v1[46:15] == 32'h12345, "R4 seconds field layout", v1[46:15], 32'h12345);

        // R7/R10: armed alarm with wakeup.
        load_time(32'h0012345, 15'h7F00);
        bus_write(6'h24, 32'h0012346);
        bus_write(6'h04, 32'hB);
        poll_ctrl(32'hB, p);
        check(irq == 1'b0, "R7 no flag before alarm second", irq, 0);
        wait_irq(6000, seen);
        check(seen, "R7 alarm fires", seen, 1);
        check(wake == 1'b1, "R10 wake with wakeup armed", wake, 1);
        bus_read(6'h18, d); check(d == 1, "R7 status flag", d, 1);
        read_count(v1);
        check(v1[46:15] == 32'h12346, "R7 fired at alarm second", v1[46:15], 32'h12346);

        // R9: write-one-to-clear.
        bus_write(6'h18, 32'h0);
        bus_read(6'h18, d); check(d == 1, "R9 writing 0 keeps flag", d, 1);
        bus_write(6'h18, 32'h1);
        bus_read(6'h18, d); check(d == 0, "R9 writing 1 clears", d, 0);
        check(irq == 1'b0, "R9 irq drops after clear", irq, 0);
        repeat (300) @(negedge bus_clk);
        bus_read(6'h18, d); check(d == 0, "R9 no re-set on same match", d, 0);

        // R10: no wakeup when not armed; irq follows the arm bit.
        load_time(32'h00000200, 15'h7F00);
        bus_write(6'h24, 32'h00000201);
        bus_write(6'h04, 32'h3);
        poll_ctrl(32'h3, p);
        wait_irq(6000, seen);
        check(seen, "R7 second alarm fires", seen, 1);
        check(wake == 1'b0, "R10 wake needs wakeup arm", wake, 0);
        bus_write(6'h04, 32'h1);
        check(irq == 1'b0, "R10 irq follows arm bit", irq, 0);
        bus_read(6'h18, d); check(d == 1, "R10 flag kept when disarmed", d, 1);
        bus_write(6'h18, 32'h1);

        // R8: unarmed alarm never sets the flag.
        load_time(32'h00000300, 15'h7F00);
        bus_write(6'h24, 32'h00000301);
        bus_write(6'h04, 32'h1);
        poll_ctrl(32'h1, p);
        repeat (4000) @(negedge bus_clk);
        read_count(v1);
        check(v1[46:15] == 32'h301, "R8 alarm second passed", v1[46:15], 32'h301);
        bus_read(6'h18, d); check(d == 0, "R8 unarmed stays clear", d, 0);
        check(irq == 1'b0, "R8 irq low", irq, 0);

        model_on = 1'b0;
        @(negedge bus_clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule